// File: doc/BRIEF.md
# Digital I/O Register Controller

This block is a sixteen-location, byte-wide register file that sits between a simple synchronous register bus and a set of digital lines. It holds latches for twenty-four output lines and for an eight-bit bidirectional TTL port. It samples twenty-four input lines and the TTL pins through a synchronizer, and a control bit selects which way the TTL port drives. Software reaches everything through byte offsets, and several offsets mean one thing on a read and another on a write.

Change-of-state detection lives in a neighbouring detector block. This controller reads that detector's status bits through four byte offsets and turns writes to those offsets into one-cycle clear pulses. It also holds the detector's enable byte. A write to the top offset starts a soft reset of the register file, and a read of the same offset returns the level of the interrupt pin.

Top module: `dio_regfile`

## Requirements
- R1: Offsets 0x0, 0x1 and 0x2 are read/write latches for output lines 0-7, 8-15 and 16-23 (offset k drives `out_lines[8k+7:8k]`). A read returns the latched value.
- R2: Offset 0x3 is the read/write latch for the TTL port and drives `ttl_out`.
- R3: Offsets 0x4, 0x5 and 0x6 read synchronized input lines 0-7, 8-15 and 16-23. Writes to them change no output and no latch.
- R4: Offset 0x7 reads the synchronized TTL pin levels. A write to it changes no output.
- R5: Bit 1 of the control byte at offset 0xC drives `ttl_oe` (1 means the TTL port drives, 0 means it is tri-stated). The whole control byte reads back as written.
- R6: Any write to offset 0xF clears the output latches, the TTL latch, the control byte and the detector enable byte at the second rising edge after the write. The outputs keep their old values for one cycle. A read of 0xF returns `irq_pin` in bit 0 with the upper bits zero.
- R7: Offset 0xD reads as zero, and a write to it has no effect.
- R8: Read data is registered. `bus_rdata` shows the addressed value in the cycle after `bus_rd`, and it is zero in any cycle that follows a cycle without `bus_rd`.
- R9: `in_sync` equals `in_lines` as it stood two clock edges earlier (two-flop synchronizer).
- R10: Offsets 0x8-0xB read `cos_status` bytes 0-3. A write to offset 0x8+k pulses the written byte on `cos_clear[8k+7:8k]` for exactly one cycle. Otherwise `cos_clear` is zero.
- R11: Offset 0xE is the read/write detector enable byte and drives `cos_en`.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| out_lines | output | 24 | Output line latches |
| in_lines | input | 24 | Asynchronous input lines |
| ttl_pins | input | 8 | TTL pin levels |
| ttl_out | output | 8 | TTL output latch |
| ttl_oe | output | 1 | TTL driver enable |
| in_sync | output | 24 | Synchronized input lines, sent to the detector |
| ttl_sync | output | 8 | Synchronized TTL pins, sent to the detector |
| cos_status | input | 32 | Change-of-state status from the detector |
| cos_clear | output | 32 | One-cycle clear pulses to the detector |
| cos_en | output | 8 | Detector enable byte |
| irq_pin | input | 1 | Interrupt pin level |

## Verification
The bench builds the block with its defaults: an 8-bit byte and a two-stage synchronizer. That makes the two-edge delay on the input lines and the TTL pins directly observable. With the TTL pins looped back from `ttl_out` while `ttl_oe` is high, one read offset shows either external pins or the port's own latch, depending on the control bit. It also places reads and writes next to a soft reset so that the one-cycle gap before clearing can be seen.

// File: rtl/dio_regfile.sv
module dio_regfile #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BANKS      = 3,
  localparam int LINES      = BYTE_W * BANKS,
  localparam int COS_W      = BYTE_W * (BANKS + 1),
  localparam int SYNC_W     = LINES + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic [LINES-1:0]  out_lines,
  input  logic [LINES-1:0]  in_lines,
  input  logic [BYTE_W-1:0] ttl_pins,
  output logic [BYTE_W-1:0] ttl_out,
  output logic              ttl_oe,
  output logic [LINES-1:0]  in_sync,
  output logic [BYTE_W-1:0] ttl_sync,
  input  logic [COS_W-1:0]  cos_status,
  output logic [COS_W-1:0]  cos_clear,
  output logic [BYTE_W-1:0] cos_en,
  input  logic              irq_pin
);
  localparam logic [3:0] A_TTL_OUT = 4'h3;
  localparam logic [3:0] A_TTL_IN  = 4'h7;
  localparam logic [3:0] A_CTRL    = 4'hC;
  localparam logic [3:0] A_EN      = 4'hE;
  localparam logic [3:0] A_SRST    = 4'hF;
  localparam int         DIR_BIT   = 1;

  logic [LINES-1:0]  out_q;
  logic [BYTE_W-1:0] ttl_q, ctrl_q, en_q, rdata_q, rd_mux;
  logic [COS_W-1:0]  clr_q;
  logic              srst_q;
  logic [SYNC_W-1:0] sync_q [SYNC_STAGES];

  int unsigned lane;
  assign lane = 32'(bus_addr[1:0]) * BYTE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= {ttl_pins, in_lines};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign in_sync  = sync_q[SYNC_STAGES-1][LINES-1:0];
  assign ttl_sync = sync_q[SYNC_STAGES-1][SYNC_W-1:LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      ttl_q  <= '0;
      ctrl_q <= '0;
      en_q   <= '0;
      clr_q  <= '0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= bus_wr && (bus_addr == A_SRST);
      clr_q  <= '0;
      if (srst_q) begin
        out_q  <= '0;
        ttl_q  <= '0;
        ctrl_q <= '0;
        en_q   <= '0;
      end else if (bus_wr) begin
        case (bus_addr)
          4'h0, 4'h1, 4'h2:         out_q[lane +: BYTE_W] <= bus_wdata;
          A_TTL_OUT:                ttl_q  <= bus_wdata;
          4'h8, 4'h9, 4'hA, 4'hB:   clr_q[lane +: BYTE_W] <= bus_wdata;
          A_CTRL:                   ctrl_q <= bus_wdata;
          A_EN:                     en_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      4'h0, 4'h1, 4'h2:       rd_mux = out_q[lane +: BYTE_W];
      A_TTL_OUT:              rd_mux = ttl_q;
      4'h4, 4'h5, 4'h6:       rd_mux = in_sync[lane +: BYTE_W];
      A_TTL_IN:               rd_mux = ttl_sync;
      4'h8, 4'h9, 4'hA, 4'hB: rd_mux = cos_status[lane +: BYTE_W];
      A_CTRL:                 rd_mux = ctrl_q;
      A_EN:                   rd_mux = en_q;
      A_SRST:                 rd_mux = {{(BYTE_W-1){1'b0}}, irq_pin};
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;
  assign out_lines = out_q;
  assign ttl_out   = ttl_q;
  assign ttl_oe    = ctrl_q[DIR_BIT];
  assign cos_en    = en_q;
  assign cos_clear = clr_q;
endmodule

// File: rtl/dio_regfile_chk.sv
module dio_regfile_chk #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LINES      = BYTE_W * 3,
  localparam int COS_W      = BYTE_W * 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        bus_addr,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [LINES-1:0]  out_lines,
  input logic [BYTE_W-1:0] ttl_out,
  input logic              ttl_oe,
  input logic [BYTE_W-1:0] cos_en,
  input logic [COS_W-1:0]  cos_clear,
  input logic [LINES-1:0]  in_lines,
  input logic [LINES-1:0]  in_sync,
  input logic              srst_q
);
  logic [3:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 4'hF) age <= age + 4'd1;
  end

  assert_ro_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'b01 && !srst_q) |=>
      ($stable(out_lines) && $stable(ttl_out) && $stable(ttl_oe)));

  assert_dir_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'hC && !srst_q) |=> (ttl_oe == $past(bus_wdata[1])));

  assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (out_lines == '0 && ttl_out == '0 && !ttl_oe && cos_en == '0));

  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

  assert_clr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[3:2] == 2'b10 && !srst_q) |=> (cos_clear == '0));

  if (SYNC_STAGES == 2) begin : g_sync_chk
    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 4'd3) |-> (in_sync == $past(in_lines, 2)));
  end
endmodule

bind dio_regfile dio_regfile_chk #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .out_lines(out_lines), .ttl_out(ttl_out), .ttl_oe(ttl_oe), .cos_en(cos_en),
  .cos_clear(cos_clear), .in_lines(in_lines), .in_sync(in_sync), .srst_q(srst_q)
);

// File: tb/dio_regfile_tb_top.sv
module dio_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] out_lines, in_lines = '0, in_sync;
  logic [7:0]  ext_ttl = '0, ttl_pins, ttl_out, ttl_sync, cos_en;
  logic        ttl_oe, irq_pin = 1'b0;
  logic [31:0] cos_status = '0, cos_clear;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #5 clk = ~clk;
  assign ttl_pins = ttl_oe ? ttl_out : ext_ttl;

  dio_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .out_lines(out_lines), .in_lines(in_lines), .ttl_pins(ttl_pins),
    .ttl_out(ttl_out), .ttl_oe(ttl_oe), .in_sync(in_sync), .ttl_sync(ttl_sync),
    .cos_status(cos_status), .cos_clear(cos_clear), .cos_en(cos_en),
    .irq_pin(irq_pin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); req_q.push_back(req);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  initial begin : monitor
    bit fired;
    forever begin
      @(posedge clk); fired = bus_rd;
      @(negedge clk);
      if (fired) begin
        if (exp_q.size() == 0) chk("R8 unexpected read", 32'(bus_rdata), 32'hDEAD);
        else chk(req_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 out_lines", 32'(out_lines), 0);
    chk("R12 ttl_oe", 32'(ttl_oe), 0);
    chk("R12 cos_en", 32'(cos_en), 0);
    chk("R12 rdata", 32'(bus_rdata), 0);

    wr(4'h0, 8'h11); wr(4'h1, 8'h22); wr(4'h2, 8'h33);
    chk("R1 out_lines", 32'(out_lines), 32'h332211);
    rd(4'h0, 8'h11, "R1 read 0x0"); rd(4'h1, 8'h22, "R1 read 0x1"); rd(4'h2, 8'h33, "R1 read 0x2");

    wr(4'h3, 8'h5A);
    chk("R2 ttl_out", 32'(ttl_out), 32'h5A);
    chk("R2 ttl_oe off", 32'(ttl_oe), 0);
    rd(4'h3, 8'h5A, "R2 read 0x3");

    in_lines = 24'hC3B2A1;
    repeat (3) @(negedge clk);
    rd(4'h4, 8'hA1, "R3 read 0x4"); rd(4'h5, 8'hB2, "R3 read 0x5"); rd(4'h6, 8'hC3, "R3 read 0x6");
    wr(4'h4, 8'hFF); wr(4'h6, 8'h00);
    chk("R3 out_lines after ro write", 32'(out_lines), 32'h332211);
    chk("R3 ttl_out after ro write", 32'(ttl_out), 32'h5A);
    rd(4'h4, 8'hA1, "R3 read after write");

    @(negedge clk); in_lines = 24'h0F0F0F;
    @(negedge clk); chk("R9 one edge", 32'(in_sync), 32'hC3B2A1);
    @(negedge clk); chk("R9 two edges", 32'(in_sync), 32'h0F0F0F);

    ext_ttl = 8'h96;
    repeat (3) @(negedge clk);
    rd(4'h7, 8'h96, "R4 read pins input mode");
    wr(4'h7, 8'h00);
    chk("R4 ttl_out after write", 32'(ttl_out), 32'h5A);

    wr(4'hC, 8'h02);
    chk("R5 ttl_oe on", 32'(ttl_oe), 1);
    repeat (3) @(negedge clk);
    rd(4'h7, 8'h5A, "R5 pins follow latch");
    rd(4'hC, 8'h02, "R5 read ctrl");
    wr(4'hC, 8'h80);
    chk("R5 ttl_oe off", 32'(ttl_oe), 0);
    rd(4'hC, 8'h80, "R5 read ctrl full byte");

    wr(4'hD, 8'hFF);
    rd(4'hD, 8'h00, "R7 reserved read");
    chk("R7 out_lines", 32'(out_lines), 32'h332211);

    wr(4'hE, 8'h3C);
    chk("R11 cos_en", 32'(cos_en), 32'h3C);
    rd(4'hE, 8'h3C, "R11 read enable");

    cos_status = 32'h44332211;
    rd(4'h8, 8'h11, "R10 read status 0"); rd(4'hB, 8'h44, "R10 read status 3");
    wr(4'h9, 8'hA5);
    chk("R10 clear pulse", cos_clear, 32'h0000A500);
    @(negedge clk);
    chk("R10 clear ends", cos_clear, 0);

    irq_pin = 1'b1; rd(4'hF, 8'h01, "R6 irq read high");
    irq_pin = 1'b0; rd(4'hF, 8'h00, "R6 irq read low");

    wr(4'hC, 8'h02);
    wr(4'hF, 8'h77);
    chk("R6 outputs held one cycle", 32'(out_lines), 32'h332211);
    @(negedge clk);
    chk("R6 out_lines cleared", 32'(out_lines), 0);
    chk("R6 ttl_out cleared", 32'(ttl_out), 0);
    chk("R6 ttl_oe cleared", 32'(ttl_oe), 0);
    chk("R6 cos_en cleared", 32'(cos_en), 0);
    rd(4'hC, 8'h00, "R6 ctrl cleared");

    rd(4'h5, 8'h0F, "R8 read before idle");
    @(negedge clk);
    chk("R8 idle rdata", 32'(bus_rdata), 0);

    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule